// File: doc/BRIEF.md
# Banked GPIO Pin Control Registers

This block holds the control state for a set of general-purpose pins, 13 by default. The pins are grouped into three banks: pins 0–6, pins 7–10 and pins 11–12. The banking is only a grouping; every pin behaves the same way. Each pin owns two byte-wide registers on a simple register port.

The output register sets the pin's direction, output value, drive style (push-pull or open-drain) and pull resistor selection. The block turns these settings into pad-side enable, data, drive-type and pull signals. The input register returns the pin's level after synchronisation and holds the pin's edge-detect mode. Each pin raises a one-cycle `edge_hit` pulse when its synchronised level changes in the selected direction. Aggregating these pulses into interrupts is left to a neighbouring block.

Writes are taken on the rising clock edge while `reg_we` is high. Read data is a combinational function of `reg_addr`.

Top module: `gpio_bank_ctl`

## Requirements
- R1: After reset, every output and input control register reads 0. Every pin is then an input with its output enable low and edge detection disabled.
- R2: The output register of pin n is at address 0x4E44+n. The input register of pin n is at 0x4E51+n, which is the output base plus the pin count.
- R3: Output register fields:
  - bit 0: output value
  - bits 2:1: pull code, driven onto `pad_pull_sel` (0 strong pull-down, 1 strong pull-up, 2 weak pull-down, 3 weak pull-up)
  - bit 3: pull enable, driven onto `pad_pull_en`
  - bit 4: drive type (1 push-pull, 0 open-drain)
  - bit 5: direction (1 output)
  - bits 7:6 read 0 and ignore writes.
- R4: With direction output and push-pull drive, `pad_oe` is 1 and `pad_do` equals the output value one cycle after the write.
- R5: With direction output and open-drain drive, an output value of 0 gives `pad_oe`=1 and `pad_do`=0. An output value of 1 gives `pad_oe`=0, so the pin floats.
- R6: With direction input, `pad_oe` is 0 whatever the other fields hold.
- R7: Input register bit 0 reads the pin level after a two-flop synchroniser. A pin change set up before clock edge k becomes visible after edge k+1. Writes to bit 0 are ignored, and bits 7:3 read 0.
- R8: Input register bits 2:1 select the edge mode: 0 disabled, 1 falling, 2 rising, 3 both. `edge_hit` pulses for exactly one cycle, in the same cycle the readback level changes, and only for a matching edge.
- R9: A read from an address outside both register ranges returns 0. A write to such an address changes no register and no pad output.
- R10: A write changes only the addressed register of the addressed pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (16) | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| pin_in | input | NUM_PINS (13) | Raw pin levels, asynchronous |
| pad_oe | output | NUM_PINS | Per-pin output enable |
| pad_do | output | NUM_PINS | Per-pin output data |
| pad_pp | output | NUM_PINS | Per-pin drive type, 1 = push-pull |
| pad_pull_en | output | NUM_PINS | Per-pin pull enable |
| pad_pull_sel | output | 2*NUM_PINS | Per-pin pull code, pin n at bits 2n+1:2n |
| edge_hit | output | NUM_PINS | Per-pin one-cycle edge-detect pulse |

## Verification
The bench builds the block with its default parameters: 13 pins, a 16-bit address, an output base of 0x4E44 and two synchroniser stages. With these values, both ends of each register range can be reached, together with the addresses just outside them on either side. The two-stage synchroniser also fixes the latency the bench expects: a pin change shows up one cycle after the first capturing edge, and the bench checks that it is not visible one cycle earlier. Four pins set to the four edge modes are toggled together, so a single rising step and a single falling step cover every mode against both edge directions.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int REG_W      = 8;
  localparam int CFG_W      = 6;
  localparam int MODE_LO    = 1;
  localparam int MODE_HI    = 2;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_RISE = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_mode_e;

  // Field order matches the output register bit positions 5..0.
  typedef struct packed {
    logic       dir;
    logic       push_pull;
    logic       pull_en;
    logic [1:0] pull_sel;
    logic       value;
  } out_cfg_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec #(
  parameter int NUM_PINS = 13,
  parameter int ADDR_W   = 16,
  parameter int OUT_BASE = 'h4E44
) (
  input  logic [ADDR_W-1:0]            addr,
  output logic                         out_hit,
  output logic                         in_hit,
  output logic [$clog2(NUM_PINS)-1:0]  pin_idx
);

  localparam int PIN_W   = $clog2(NUM_PINS);
  localparam int IN_BASE = OUT_BASE + NUM_PINS;
  localparam int OFF_W   = ADDR_W + 1;

  logic [OFF_W-1:0] out_off;
  logic [OFF_W-1:0] in_off;

  // An address below a base wraps to a large offset and misses.
  always_comb begin
    out_off = {1'b0, addr} - OFF_W'(OUT_BASE);
    in_off  = {1'b0, addr} - OFF_W'(IN_BASE);
    out_hit = out_off < OFF_W'(NUM_PINS);
    in_hit  = in_off  < OFF_W'(NUM_PINS);
    if (out_hit)     pin_idx = out_off[PIN_W-1:0];
    else if (in_hit) pin_idx = in_off[PIN_W-1:0];
    else             pin_idx = '0;
  end

endmodule

// File: rtl/gpio_pin_slot.sv
module gpio_pin_slot
  import gpio_bank_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_out,
  input  logic                  wr_in,
  input  logic [CFG_W-1:0]      cfg_wdata,
  input  logic [1:0]            mode_wdata,
  input  logic                  pin_raw,
  output logic [REG_W-1:0]      out_rd,
  output logic [REG_W-1:0]      in_rd,
  output logic                  pad_oe,
  output logic                  pad_do,
  output logic                  pad_pp,
  output logic                  pad_pull_en,
  output logic [1:0]            pad_pull_sel,
  output logic                  edge_hit
);

  out_cfg_t   cfg_q, cfg_d;
  edge_mode_e mode_q, mode_d;
  logic       lvl_s;
  logic       lvl_prev_q;
  logic       rise, fall;

  gpio_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_raw),
    .q     (lvl_s)
  );

  always_comb begin
    cfg_d  = cfg_q;
    mode_d = mode_q;
    if (wr_out) cfg_d  = out_cfg_t'(cfg_wdata);
    if (wr_in)  mode_d = edge_mode_e'(mode_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      mode_q     <= EDGE_OFF;
      lvl_prev_q <= 1'b0;
    end else begin
      if (wr_out) cfg_q  <= cfg_d;
      if (wr_in)  mode_q <= mode_d;
      lvl_prev_q <= lvl_s;
    end
  end

  always_comb begin
    rise = lvl_s & ~lvl_prev_q;
    fall = ~lvl_s & lvl_prev_q;
    unique case (mode_q)
      EDGE_FALL: edge_hit = fall;
      EDGE_RISE: edge_hit = rise;
      EDGE_ANY:  edge_hit = rise | fall;
      default:   edge_hit = 1'b0;
    endcase
  end

  // Open-drain releases the pin for a 1; push-pull always drives.
  assign pad_oe       = cfg_q.dir & (cfg_q.push_pull | ~cfg_q.value);
  assign pad_do       = cfg_q.value;
  assign pad_pp       = cfg_q.push_pull;
  assign pad_pull_en  = cfg_q.pull_en;
  assign pad_pull_sel = cfg_q.pull_sel;

  assign out_rd = {{(REG_W-CFG_W){1'b0}}, cfg_q};
  assign in_rd  = {{(REG_W-3){1'b0}}, mode_q, lvl_s};

  AST_DIR_IN_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_out && !cfg_wdata[5]) |=> !pad_oe) else $error("input dir drives"); // R6

  AST_OD_HIGH_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_out && cfg_wdata[5] && !cfg_wdata[4] && cfg_wdata[0]) |=> !pad_oe)
    else $error("open-drain high drives"); // R5

  AST_PP_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_out && cfg_wdata[5] && cfg_wdata[4]) |=> (pad_oe && pad_do == $past(cfg_wdata[0])))
    else $error("push-pull not driving"); // R4

  AST_EDGE_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_in && mode_wdata == 2'd0) |=> !edge_hit) else $error("edge while off"); // R8

endmodule

// File: rtl/gpio_bank_ctl.sv
module gpio_bank_ctl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS    = 13,
  parameter int ADDR_W      = 16,
  parameter int OUT_BASE    = 'h4E44,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [7:0]            reg_wdata,
  output logic [7:0]            reg_rdata,
  input  logic [NUM_PINS-1:0]   pin_in,
  output logic [NUM_PINS-1:0]   pad_oe,
  output logic [NUM_PINS-1:0]   pad_do,
  output logic [NUM_PINS-1:0]   pad_pp,
  output logic [NUM_PINS-1:0]   pad_pull_en,
  output logic [2*NUM_PINS-1:0] pad_pull_sel,
  output logic [NUM_PINS-1:0]   edge_hit
);

  localparam int PIN_W = $clog2(NUM_PINS);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             out_hit, in_hit;
  logic [PIN_W-1:0] pin_idx;
  logic [NUM_PINS-1:0] out_sel, in_sel;
  logic [REG_W-1:0] out_rd [NUM_PINS];
  logic [REG_W-1:0] in_rd  [NUM_PINS];
  logic [1:0]       wdata_unused;

  assign wdata_unused = reg_wdata[7:6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  gpio_addr_dec #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W),
    .OUT_BASE (OUT_BASE)
  ) u_dec (
    .addr    (reg_addr),
    .out_hit (out_hit),
    .in_hit  (in_hit),
    .pin_idx (pin_idx)
  );

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      assign out_sel[i] = out_hit && (pin_idx == PIN_W'(i));
      assign in_sel[i]  = in_hit  && (pin_idx == PIN_W'(i));

      gpio_pin_slot #(.SYNC_STAGES(SYNC_STAGES)) u_slot (
        .clk          (clk),
        .rst_n        (rst_int_n),
        .wr_out       (reg_we && out_sel[i]),
        .wr_in        (reg_we && in_sel[i]),
        .cfg_wdata    (reg_wdata[CFG_W-1:0]),
        .mode_wdata   (reg_wdata[MODE_HI:MODE_LO]),
        .pin_raw      (pin_in[i]),
        .out_rd       (out_rd[i]),
        .in_rd        (in_rd[i]),
        .pad_oe       (pad_oe[i]),
        .pad_do       (pad_do[i]),
        .pad_pp       (pad_pp[i]),
        .pad_pull_en  (pad_pull_en[i]),
        .pad_pull_sel (pad_pull_sel[2*i+1:2*i]),
        .edge_hit     (edge_hit[i])
      );
    end
  endgenerate

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (out_sel[i]) reg_rdata = reg_rdata | out_rd[i];
      if (in_sel[i])  reg_rdata = reg_rdata | in_rd[i];
    end
  end

  AST_MISS_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reg_we && !out_hit && !in_hit) |=>
      ($stable(pad_oe) && $stable(pad_do) && $stable(pad_pp) &&
       $stable(pad_pull_en) && $stable(pad_pull_sel)))
    else $error("out-of-range write changed pads"); // R9

  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({out_sel, in_sel})) else $error("multiple targets"); // R10

endmodule

// File: tb/tb_gpio_bank_ctl.sv
`timescale 1ns/1ps
module tb_gpio_bank_ctl;

  localparam int N = 13;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_we;
  logic [15:0]   reg_addr;
  logic [7:0]    reg_wdata;
  logic [7:0]    reg_rdata;
  logic [N-1:0]  pin_in;
  logic [N-1:0]  pad_oe, pad_do, pad_pp, pad_pull_en, edge_hit;
  logic [2*N-1:0] pad_pull_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  gpio_bank_ctl dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pad_oe(pad_oe), .pad_do(pad_do), .pad_pp(pad_pp),
    .pad_pull_en(pad_pull_en), .pad_pull_sel(pad_pull_sel), .edge_hit(edge_hit)
  );

  // {address, write data, expected readback}
  localparam int NV = 9;
  localparam logic [31:0] VEC [NV] = '{
    {16'h4E44, 8'hFF, 8'h3F},   // R3 pin0 out, bits 7:6 dropped
    {16'h4E50, 8'h35, 8'h35},   // R2 last out reg
    {16'h4E51, 8'h07, 8'h06},   // R7 bit0 write ignored
    {16'h4E5D, 8'hFE, 8'h06},   // R7 bits 7:3 read 0, last in reg
    {16'h4E5E, 8'hFF, 8'h00},   // R9 past end
    {16'h4E43, 8'hFF, 8'h00},   // R9 before start
    {16'h4E48, 8'h2A, 8'h2A},   // R2 pin4 out
    {16'h4E57, 8'h04, 8'h04},   // R8 pin6 rising
    {16'h4E44, 8'hC0, 8'h00}    // R10 pin0 out cleared, upper bits dropped
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; pin_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    for (int i = 0; i < 2*N; i++) begin
      rd(16'h4E44 + 16'(i), d);
      chk("R1 reg reset", d, 0);
    end
    chk("R1 pad_oe reset", pad_oe, 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      wr(VEC[v][31:16], VEC[v][15:8]);
      rd(VEC[v][31:16], d);
      chk("R2/R3/R7/R9 table", d, VEC[v][7:0]);
    end
    rd(16'h4E50, d); chk("R10 pin12 out kept", d, 8'h35);
    rd(16'h4E5D, d); chk("R10 pin12 in kept", d, 8'h06);

    // R9 out-of-range write leaves pads alone
    wr(16'h4E44, 8'h31);
    wr(16'h4E43, 8'h00);
    chk("R9 pads after miss", {pad_oe[0], pad_do[0]}, 2'b11);

    // R4 push-pull
    wr(16'h4E45, 8'h31);
    chk("R4 pp high", {pad_oe[1], pad_do[1], pad_pp[1]}, 3'b111);
    wr(16'h4E45, 8'h30);
    chk("R4 pp low", {pad_oe[1], pad_do[1]}, 2'b10);

    // R5 open-drain
    wr(16'h4E46, 8'h21);
    chk("R5 od high floats", {pad_oe[2], pad_pp[2]}, 2'b00);
    wr(16'h4E46, 8'h20);
    chk("R5 od low drives", {pad_oe[2], pad_do[2]}, 2'b10);

    // R6 input direction
    wr(16'h4E47, 8'h11);
    chk("R6 input no drive", pad_oe[3], 1'b0);

    // R3 pull fields
    wr(16'h4E48, 8'h0E);
    chk("R3 pull en/sel", {pad_pull_en[4], pad_pull_sel[9:8]}, 3'b111);
    wr(16'h4E48, 8'h04);
    chk("R3 pull off weak-down code", {pad_pull_en[4], pad_pull_sel[9:8]}, 3'b010);
    chk("R10 pin1 untouched", {pad_oe[1], pad_do[1]}, 2'b10);

    // R7/R8 edges: pin5 fall, pin6 rise, pin7 off, pin8 both
    wr(16'h4E56, 8'h02);
    wr(16'h4E58, 8'h00);
    wr(16'h4E59, 8'h06);
    @(negedge clk);
    reg_addr = 16'h4E57;
    pin_in[8:5] = 4'b1111;
    @(posedge clk); @(negedge clk);
    chk("R7 not yet visible", reg_rdata, 8'h04);
    chk("R8 no early edge", edge_hit, 0);
    @(posedge clk); @(negedge clk);
    chk("R7 level after sync", reg_rdata, 8'h05);
    chk("R8 rising hits", edge_hit[8:5], 4'b1010);
    @(posedge clk); @(negedge clk);
    chk("R8 one-cycle pulse", edge_hit, 0);
    pin_in[8:5] = 4'b0000;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R8 falling hits", edge_hit[8:5], 4'b1001);
    chk("R7 level low", reg_rdata, 8'h04);
    @(posedge clk); @(negedge clk);
    chk("R8 pulse ends", edge_hit, 0);

    finish_run();
  end

endmodule